// File: doc/BRIEF.md
# Bus Fault Status Word Capture and Restore

This block records what a bus cycle was doing at the moment it faulted, and later decides whether to repeat that cycle. The bus controller presents a descriptor of the active cycle continuously: direction, a read-modify-write flag, a prefetch flag, a released-write flag, the three function-code lines, and the original and remaining operand sizes. A fault strobe latches a packed 16-bit status word built from that descriptor. A breakpoint-pending input is latched into the same word without interpretation.

When the exception handler returns, a restore strobe presents a status word, which may have been edited. Only the rerun flag matters for the decision. When the rerun flag is set, the block reloads the direction, size and function code into registered outputs for the bus controller and pulses a rerun request. When the rerun flag is clear, nothing is reloaded and no rerun occurs. A rerun word that carries the reserved size code raises an error pulse instead of a rerun.

Status word layout, which the handler and the restore path both decode: bit 15 is rerun, bit 11 is breakpoint pending, bit 8 is read-modify-write, bit 7 is instruction prefetch, bit 6 is direction (1 = read), bit 5 is long, bits 4:3 are size, and bits 2:0 are the function code. Bits 14:12 and 10:9 are unused.

Top module: `bus_fault_status`

## Requirements
- R1: After reset, `stat_o`, `rerun_o`, `restore_err_o` and all reload outputs are 0. `stat_o` takes the new word on the first clock edge at which `fault_i` is high, and keeps its value at every edge at which `fault_i` is low.
- R2: Bit 15 (rerun) of the captured word is 1 only for a released write. That means `cyc_released_i`=1, `cyc_read_i`=0, `cyc_rmw_i`=0 and `cyc_prefetch_i`=0. In every other case bit 15 is 0.
- R3: Bit 8 equals `cyc_rmw_i`. Bit 7 equals `cyc_prefetch_i`. Bit 6 is 1 when the cycle is a prefetch or a read, and 0 for an operand write.
- R4: Sizes use the encoding 00 = long, 01 = byte, 10 = word, 11 = reserved. Bit 5 is 1 exactly when the original size is long. Bits 4:3 depend on the original size. A byte original gives 01. A long original whose remaining size is long gives 00. Every other case gives 10: a word original, a reserved original, or a long original whose remaining size is not long. Byte is therefore never reported for a long original.
- R5: Bits 2:0 copy `cyc_fc_i`, and bit 11 copies `bkpt_i`.
- R6: Bits 14:12 and 10:9 of the captured word are always 0.
- R7: A restore word with bit 15 set and bits 4:3 not equal to 11 causes three things on the next clock edge. `rerun_o` pulses high for one cycle. `reload_read_o` takes bit 6, `reload_size_o` takes bits 4:3, and `reload_fc_o` takes bits 2:0.
- R8: A restore word with bit 15 clear raises neither `rerun_o` nor `restore_err_o`, and leaves the reload outputs unchanged.
- R9: On restore, bits 14:7 and bit 5 have no effect on `rerun_o`, `restore_err_o` or the reload outputs.
- R10: A restore word with bit 15 set and bits 4:3 equal to 11 pulses `restore_err_o` for one cycle on the next clock edge. It raises no rerun and leaves the reload outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | Capture strobe |
| cyc_read_i | input | 1 | Active cycle is a read |
| cyc_rmw_i | input | 1 | Active cycle is part of a read-modify-write |
| cyc_prefetch_i | input | 1 | Active cycle is an instruction prefetch |
| cyc_released_i | input | 1 | Active write was released (overlapped) |
| cyc_fc_i | input | 3 | Function code of the active cycle |
| cyc_orig_size_i | input | 2 | Original operand size |
| cyc_rem_size_i | input | 2 | Remaining operand size |
| bkpt_i | input | 1 | Breakpoint pending, carried into the word |
| stat_o | output | 16 | Captured status word |
| restore_i | input | 1 | Restore strobe |
| restore_word_i | input | 16 | Status word returned by the handler |
| rerun_o | output | 1 | Single-cycle rerun request |
| reload_read_o | output | 1 | Reloaded direction |
| reload_size_o | output | 2 | Reloaded size |
| reload_fc_o | output | 3 | Reloaded function code |
| restore_err_o | output | 1 | Single-cycle reserved-size error |

## Verification
The bench builds the block with its only configuration: a 3-bit function code and a 16-bit status word. Because this configuration is so small, the capture side can be swept completely. The bench applies all 4096 combinations of the cycle descriptor, the breakpoint input and both size inputs, and checks every field of each captured word. On the restore side it sweeps every value of the rerun flag, size, function code and direction, each crossed with eight patterns in the bits that restore must ignore. It also checks that `rerun_o` and `restore_err_o` fall again one cycle later.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;
  localparam int STAT_W = 16;
  localparam int FC_W   = 3;
  localparam int SZ_W   = 2;

  // field positions decoded by the restore path
  localparam int POS_RERUN = 15;
  localparam int POS_BKPT  = 11;
  localparam int POS_RMW   = 8;
  localparam int POS_INS   = 7;
  localparam int POS_READ  = 6;
  localparam int POS_LONG  = 5;
  localparam int POS_SZ_LO = 3;
  localparam int POS_FC_LO = 0;

  localparam logic [STAT_W-1:0] USED_MASK =
      STAT_W'(1 << POS_RERUN) | STAT_W'(1 << POS_BKPT) | STAT_W'(1 << POS_RMW) |
      STAT_W'(1 << POS_INS)   | STAT_W'(1 << POS_READ) | STAT_W'(1 << POS_LONG) |
      STAT_W'(((1 << SZ_W) - 1) << POS_SZ_LO) | STAT_W'(((1 << FC_W) - 1) << POS_FC_LO);

  typedef enum logic [SZ_W-1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef struct packed {
    logic            read;
    logic            rmw;
    logic            prefetch;
    logic            released;
    logic [FC_W-1:0] fc;
    size_e           orig_size;
    size_e           rem_size;
    logic            bkpt;
  } cyc_desc_t;

  typedef struct packed {
    logic            read;
    size_e           size;
    logic [FC_W-1:0] fc;
  } reload_t;
endpackage

// File: rtl/fault_size_enc.sv
module fault_size_enc
  import bus_fault_pkg::*;
(
  input  size_e orig_i,
  input  size_e rem_i,
  output logic  long_o,
  output size_e size_o
);
  always_comb begin
    long_o = (orig_i == SZ_LONG);
    unique case (orig_i)
      SZ_BYTE: size_o = SZ_BYTE;
      SZ_LONG: size_o = (rem_i == SZ_LONG) ? SZ_LONG : SZ_WORD; // no byte for long originals
      default: size_o = SZ_WORD;
    endcase
  end
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import bus_fault_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  cyc_desc_t         cyc_i,
  output logic [STAT_W-1:0] stat_o
);
  logic              long_w;
  size_e             size_w;
  logic              is_write;
  logic [STAT_W-1:0] word_d;

  fault_size_enc i_size_enc (
    .orig_i (cyc_i.orig_size),
    .rem_i  (cyc_i.rem_size),
    .long_o (long_w),
    .size_o (size_w)
  );

  assign is_write = !cyc_i.read && !cyc_i.prefetch;

  always_comb begin
    word_d = '0;
    word_d[POS_RERUN] = cyc_i.released && is_write && !cyc_i.rmw;
    word_d[POS_BKPT]  = cyc_i.bkpt;
    word_d[POS_RMW]   = cyc_i.rmw;
    word_d[POS_INS]   = cyc_i.prefetch;
    word_d[POS_READ]  = !is_write;
    word_d[POS_LONG]  = long_w;
    word_d[POS_SZ_LO +: SZ_W] = size_w;
    word_d[POS_FC_LO +: FC_W] = cyc_i.fc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_o <= '0;
    else if (fault_i) stat_o <= word_d;
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & ~USED_MASK) == '0); // R6
  AST_RERUN_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[POS_RERUN] |-> !stat_o[POS_READ] && !stat_o[POS_RMW] && !stat_o[POS_INS]); // R2
  AST_BYTE_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[POS_SZ_LO +: SZ_W] == SZ_BYTE |-> !stat_o[POS_LONG]); // R4
  AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i |=> $stable(stat_o)); // R1
endmodule

// File: rtl/fault_restore.sv
module fault_restore
  import bus_fault_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restore_i,
  input  logic [STAT_W-1:0] word_i,
  output logic              rerun_o,
  output logic              err_o,
  output reload_t           reload_o
);
  logic    want_rerun;
  logic    bad_size;
  reload_t reload_d;

  assign want_rerun = restore_i && word_i[POS_RERUN];
  assign bad_size   = (word_i[POS_SZ_LO +: SZ_W] == SZ_RSVD);

  always_comb begin
    reload_d.read = word_i[POS_READ];
    reload_d.size = size_e'(word_i[POS_SZ_LO +: SZ_W]);
    reload_d.fc   = word_i[POS_FC_LO +: FC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rerun_o  <= 1'b0;
      err_o    <= 1'b0;
      reload_o <= '0;
    end else begin
      rerun_o <= want_rerun && !bad_size;
      err_o   <= want_rerun && bad_size;
      if (want_rerun && !bad_size) reload_o <= reload_d;
    end
  end

  AST_RERUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && !word_i[POS_RERUN] |=> !rerun_o && !err_o); // R8
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rerun_o && err_o)); // R10
  AST_RELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rerun_o |-> $stable(reload_o)); // R7
  AST_ERR_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i && word_i[POS_RERUN] && bad_size |=> err_o && !rerun_o); // R10
endmodule

// File: rtl/bus_fault_status.sv
module bus_fault_status
  import bus_fault_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              cyc_read_i,
  input  logic              cyc_rmw_i,
  input  logic              cyc_prefetch_i,
  input  logic              cyc_released_i,
  input  logic [FC_W-1:0]   cyc_fc_i,
  input  logic [SZ_W-1:0]   cyc_orig_size_i,
  input  logic [SZ_W-1:0]   cyc_rem_size_i,
  input  logic              bkpt_i,
  output logic [STAT_W-1:0] stat_o,
  input  logic              restore_i,
  input  logic [STAT_W-1:0] restore_word_i,
  output logic              rerun_o,
  output logic              reload_read_o,
  output logic [SZ_W-1:0]   reload_size_o,
  output logic [FC_W-1:0]   reload_fc_o,
  output logic              restore_err_o
);
  cyc_desc_t cyc;
  reload_t   reload;

  always_comb begin
    cyc.read      = cyc_read_i;
    cyc.rmw       = cyc_rmw_i;
    cyc.prefetch  = cyc_prefetch_i;
    cyc.released  = cyc_released_i;
    cyc.fc        = cyc_fc_i;
    cyc.orig_size = size_e'(cyc_orig_size_i);
    cyc.rem_size  = size_e'(cyc_rem_size_i);
    cyc.bkpt      = bkpt_i;
  end

  fault_capture i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_i),
    .cyc_i   (cyc),
    .stat_o  (stat_o)
  );

  fault_restore i_restore (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restore_i (restore_i),
    .word_i    (restore_word_i),
    .rerun_o   (rerun_o),
    .err_o     (restore_err_o),
    .reload_o  (reload)
  );

  assign reload_read_o = reload.read;
  assign reload_size_o = reload.size;
  assign reload_fc_o   = reload.fc;

  AST_RERUN_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerun_o |-> $past(restore_i) && $past(restore_word_i[POS_RERUN])); // R7
endmodule

// File: tb/test_bus_fault_status.sv
`timescale 1ns/1ps
module test_bus_fault_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fault_i = 1'b0;
  logic        cyc_read_i = 1'b0, cyc_rmw_i = 1'b0, cyc_prefetch_i = 1'b0, cyc_released_i = 1'b0;
  logic [2:0]  cyc_fc_i = '0;
  logic [1:0]  cyc_orig_size_i = '0, cyc_rem_size_i = '0;
  logic        bkpt_i = 1'b0;
  logic [15:0] stat_o;
  logic        restore_i = 1'b0;
  logic [15:0] restore_word_i = '0;
  logic        rerun_o, reload_read_o, restore_err_o;
  logic [1:0]  reload_size_o;
  logic [2:0]  reload_fc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  bus_fault_status i_bus_fault_status (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 195000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic       e_read, e_long, e_rr;
    logic [1:0] e_size;
    logic [2:0] m_fc;
    logic [1:0] m_size;
    logic       m_read;
    logic [15:0] w, prev;

    #10 @(negedge clk_i);
    chk("R1 reset stat", stat_o, 16'h0);
    chk("R1 reset outs", {rerun_o, restore_err_o, reload_read_o, reload_size_o, reload_fc_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // capture sweep
    for (int v = 0; v < 4096; v++) begin
      {cyc_read_i, cyc_rmw_i, cyc_prefetch_i, cyc_released_i, bkpt_i} = 5'(v >> 7);
      cyc_fc_i        = 3'(v >> 4);
      cyc_orig_size_i = 2'(v >> 2);
      cyc_rem_size_i  = 2'(v);
      fault_i = 1'b1;
      @(negedge clk_i);
      fault_i = 1'b0;
      e_read = cyc_read_i | cyc_prefetch_i;
      e_rr   = cyc_released_i & ~e_read & ~cyc_rmw_i;
      e_long = (cyc_orig_size_i == 2'd0);
      e_size = (cyc_orig_size_i == 2'd1) ? 2'd1 :
               (cyc_orig_size_i == 2'd0 && cyc_rem_size_i == 2'd0) ? 2'd0 : 2'd2;
      chk("R2 rerun bit", stat_o[15], e_rr);
      chk("R3 rmw/ins/dir", stat_o[8:6], {cyc_rmw_i, cyc_prefetch_i, e_read});
      chk("R4 long/size", stat_o[5:3], {e_long, e_size});
      chk("R5 fc/bkpt", {stat_o[11], stat_o[2:0]}, {bkpt_i, cyc_fc_i});
      chk("R6 unused", {stat_o[14:12], stat_o[10:9]}, 0);
      if (v % 64 == 0) begin
        prev = stat_o;
        {cyc_read_i, cyc_rmw_i, cyc_prefetch_i, cyc_released_i, bkpt_i} ^= 5'h1f;
        cyc_fc_i = ~cyc_fc_i;
        @(negedge clk_i);
        chk("R1 hold without strobe", stat_o, prev);
      end
    end

    // restore sweep
    m_read = 0; m_size = 0; m_fc = 0;
    for (int v = 0; v < 1024; v++) begin
      w = '0;
      w[15]  = v[9];
      w[4:3] = 2'(v >> 7);
      w[2:0] = 3'(v >> 4);
      w[6]   = v[3];
      // ignored bits: 14:7 and 5
      w[8]   = v[0];
      w[7]   = v[1];
      w[5]   = v[2];
      w[14:9] = v[0] ? 6'h3f : (v[1] ? 6'h2a : 6'h00);
      restore_word_i = w;
      restore_i = 1'b1;
      @(negedge clk_i);
      restore_i = 1'b0;
      if (w[15] && w[4:3] != 2'b11) begin
        m_read = w[6]; m_size = w[4:3]; m_fc = w[2:0];
        chk("R7 rerun pulse", {rerun_o, restore_err_o}, 2'b10);
      end else if (w[15]) begin
        chk("R10 reserved size err", {rerun_o, restore_err_o}, 2'b01);
      end else begin
        chk("R8 no rerun", {rerun_o, restore_err_o}, 2'b00);
      end
      chk("R9 reload ignores other bits", {reload_read_o, reload_size_o, reload_fc_o},
          {m_read, m_size, m_fc});
      restore_word_i = 16'hffff;
      @(negedge clk_i);
      chk("R7 single-cycle pulse", {rerun_o, restore_err_o}, 2'b00);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule